// File: doc/BRIEF.md
# Nibble-Programmed Bank Mapper

This block sits between an 8-bit CPU bus, a separate graphics bus and the memories of a cartridge. It turns CPU addresses into program-ROM or work-RAM addresses, and graphics addresses into pattern-memory addresses. Every bank register is eight bits wide but is loaded four bits at a time. A CPU write into the upper half of the address space picks a register and one of its two nibbles. The other nibble keeps its value.

The CPU sees four 8 KB program windows. Three of them can be switched. The top window always holds the final ROM bank. The graphics bus sees eight 1 KB pattern windows. A control register gates the 8 KB work RAM: it can be off, read-only, or read-write. A second control register picks the nametable mirroring mode, which appears as a single page-select output. All translation is combinational. A register write takes effect in the cycle after the clock edge that captures it.

Top module: `nibble_bank_mapper`

## Requirements
- R1: After reset, every bank register is 0, the work RAM is disabled (ram_cs stays low), and mirroring is horizontal.
- R2: A write (cpu_valid=1, cpu_we=1, cpu_addr[15]=1) is decoded on cpu_addr AND 0xF003. If cpu_addr[0]=0, cpu_wdata[3:0] replaces bits [3:0] of the selected bank register. If cpu_addr[0]=1, cpu_wdata[3:0] replaces bits [7:4]. The other nibble is unchanged, and the new value is visible from the next clock edge.
- R3: The window at $8000 is loaded through decodes 0x8000/0x8001, the window at $A000 through 0x8002/0x8003, and the window at $C000 through 0x9000/0x9001. On a valid read of these windows, prg_rom_addr = {bank mod PRG_BANKS, cpu_addr[12:0]}.
- R4: On a valid read of $E000-$FFFF, prg_rom_addr = {PRG_BANKS-1, cpu_addr[12:0]}, whatever has been written.
- R5: Graphics window k (ppu_addr[12:10]=k) is loaded through decodes 0xA000+0x1000*(k/2)+2*(k%2) and that value plus 1. chr_addr = {bank mod CHR_BANKS, ppu_addr[9:0]}. chr_cs is 1 exactly when ppu_addr[13]=0.
- R6: Decode 0x9002 sets the RAM control. Bit 0 enables the RAM. Bit 1 allows writes, but only while bit 0 is set. For a valid access to $6000-$7FFF with the RAM enabled: ram_cs=1, ram_oe is 1 on a read, and ram_we is 1 on a write only if writes are allowed. If the RAM is disabled, all three stay 0. ram_addr = cpu_addr[12:0].
- R7: prg_rom_cs is 1 exactly on a valid read with cpu_addr[15]=1.
- R8: Decode 0xF002 bits [1:0] set the mirroring mode, and nt_page follows it: 0 (horizontal) gives ppu_addr[11], 1 (vertical) gives ppu_addr[10], 2 (single-screen A) gives 0, and 3 (single-screen B) gives 1.
- R9: The following writes change no register: decodes 0xF003, 0x9003, 0xE000-0xE003, 0xF000, 0xF001, and any write below $8000.
- R10: cpu_addr bits [11:2] play no part in decoding, so every alias of a decode address reaches the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU bus cycle active |
| cpu_we | input | 1 | CPU cycle is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Graphics bus address |
| prg_rom_addr | output | log2(PRG_BANKS)+13 | Program ROM address |
| prg_rom_cs | output | 1 | Program ROM select |
| ram_addr | output | 13 | Work RAM address |
| ram_cs | output | 1 | Work RAM select |
| ram_oe | output | 1 | Work RAM output enable (drives the data bus) |
| ram_we | output | 1 | Work RAM write strobe |
| chr_addr | output | log2(CHR_BANKS)+10 | Pattern memory address |
| chr_cs | output | 1 | Pattern memory select |
| nt_page | output | 1 | Nametable page select from mirroring mode |

## Verification
The hardest case to reach is a nibble write that must leave the other half of a register untouched. The register itself is not visible, so that untouched half only shows up in the high bits of a translated address, and only once both halves hold distinct, non-zero values. The stimulus therefore first fills both nibbles of each register, then rewrites one half at a time. After each rewrite it reads the full translated address back through the matching window. Random aliased writes are mixed in, with bits [11:2] randomized, together with writes to the ignored decodes. A full sweep of all windows then confirms that nothing else moved.

// File: rtl/nbm_pkg.sv
`timescale 1ns/1ps
package nbm_pkg;
   localparam int NIB_W     = 4;
   localparam int BANK_W    = 2 * NIB_W;
   localparam int NUM_PRG   = 3;
   localparam int NUM_CHR   = 8;
   localparam int PRG_OFS_W = 13;
   localparam int CHR_OFS_W = 10;

   typedef enum logic [1:0] {
      MIR_HORZ  = 2'd0,
      MIR_VERT  = 2'd1,
      MIR_ONE_A = 2'd2,
      MIR_ONE_B = 2'd3
   } mirror_e;

   typedef logic [NUM_PRG-1:0][BANK_W-1:0] prg_banks_t;
   typedef logic [NUM_CHR-1:0][BANK_W-1:0] chr_banks_t;
endpackage

// File: rtl/nbm_nibble_reg.sv
`timescale 1ns/1ps
module nbm_nibble_reg #(
   parameter int NW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [NW-1:0]   din,
   output logic [2*NW-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         if (wr_lo) q[NW-1:0]    <= din;
         if (wr_hi) q[2*NW-1:NW] <= din;
      end
   end
endmodule

// File: rtl/nbm_regfile.sv
`timescale 1ns/1ps
module nbm_regfile
   import nbm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] addr,
   input  logic [7:0]  wdata,
   output prg_banks_t  prg_bank,
   output chr_banks_t  chr_bank,
   output logic        ram_en,
   output logic        ram_wr,
   output mirror_e     mirror
);
   logic       hit, nib_hi;
   logic [2:0] grp;
   logic       prg_hit, chr_hit, ramctl_hit, mir_hit;
   logic [1:0] prg_idx;
   logic [2:0] grp_rel;
   logic [2:0] chr_idx;
   logic       unused_dec;

   assign hit     = wr_en & addr[15];
   assign nib_hi  = addr[0];
   assign grp     = addr[14:12];
   assign grp_rel = grp - 3'd2;

   always_comb begin
      prg_hit    = 1'b0;
      chr_hit    = 1'b0;
      ramctl_hit = 1'b0;
      mir_hit    = 1'b0;
      prg_idx    = 2'd0;
      chr_idx    = {grp_rel[1:0], addr[1]};
      if (hit) begin
         unique case (grp)
            3'd0: begin
               prg_hit = 1'b1;
               prg_idx = {1'b0, addr[1]};
            end
            3'd1: begin
               if (!addr[1]) begin
                  prg_hit = 1'b1;
                  prg_idx = 2'd2;
               end else if (!addr[0]) begin
                  ramctl_hit = 1'b1;
               end
            end
            3'd2, 3'd3, 3'd4, 3'd5: chr_hit = 1'b1;
            3'd7:    mir_hit = (addr[1:0] == 2'b10);
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_PRG; g++) begin : g_prg
      nbm_nibble_reg #(.NW(NIB_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (prg_hit && prg_idx == 2'(g) && !nib_hi),
         .wr_hi (prg_hit && prg_idx == 2'(g) &&  nib_hi),
         .din   (wdata[NIB_W-1:0]),
         .q     (prg_bank[g])
      );
   end

   for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
      nbm_nibble_reg #(.NW(NIB_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (chr_hit && chr_idx == 3'(g) && !nib_hi),
         .wr_hi (chr_hit && chr_idx == 3'(g) &&  nib_hi),
         .din   (wdata[NIB_W-1:0]),
         .q     (chr_bank[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_en <= 1'b0;
         ram_wr <= 1'b0;
         mirror <= MIR_HORZ;
      end else begin
         if (ramctl_hit) begin
            ram_en <= wdata[0];
            ram_wr <= wdata[1];
         end
         if (mir_hit) mirror <= mirror_e'(wdata[1:0]);
      end
   end

   assign unused_dec = ^{addr[11:2], wdata[7:4], grp_rel[2]};
endmodule

// File: rtl/nbm_prg_xlate.sv
`timescale 1ns/1ps
module nbm_prg_xlate
   import nbm_pkg::*;
#(
   parameter int PRG_BW   = 5,
   parameter bit HAS_WRAM = 1'b1
) (
   input  logic                        cpu_valid,
   input  logic                        cpu_we,
   input  logic [15:0]                 cpu_addr,
   input  prg_banks_t                  prg_bank,
   input  logic                        ram_en,
   input  logic                        ram_wr,
   output logic [PRG_BW+PRG_OFS_W-1:0] prg_rom_addr,
   output logic                        prg_rom_cs,
   output logic [PRG_OFS_W-1:0]        ram_addr,
   output logic                        ram_cs,
   output logic                        ram_oe,
   output logic                        ram_we
);
   logic [BANK_W-1:0] sel_bank;
   logic              unused_bits;

   always_comb begin
      unique case (cpu_addr[14:13])
         2'd0:    sel_bank = prg_bank[0];
         2'd1:    sel_bank = prg_bank[1];
         2'd2:    sel_bank = prg_bank[2];
         default: sel_bank = '1;
      endcase
   end

   assign prg_rom_addr = {sel_bank[PRG_BW-1:0], cpu_addr[PRG_OFS_W-1:0]};
   assign prg_rom_cs   = cpu_valid & ~cpu_we & cpu_addr[15];
   assign ram_addr     = cpu_addr[PRG_OFS_W-1:0];

   if (HAS_WRAM) begin : g_wram
      logic in_ram;
      assign in_ram = cpu_valid & (cpu_addr[15:13] == 3'b011) & ram_en;
      assign ram_cs = in_ram;
      assign ram_oe = in_ram & ~cpu_we;
      assign ram_we = in_ram & cpu_we & ram_wr;
   end else begin : g_no_wram
      assign ram_cs = 1'b0;
      assign ram_oe = 1'b0;
      assign ram_we = 1'b0;
   end

   assign unused_bits = ^{sel_bank, ram_en, ram_wr};
endmodule

// File: rtl/nbm_chr_xlate.sv
`timescale 1ns/1ps
module nbm_chr_xlate
   import nbm_pkg::*;
#(
   parameter int CHR_BW = 8
) (
   input  logic [13:0]                 ppu_addr,
   input  chr_banks_t                  chr_bank,
   input  mirror_e                     mirror,
   output logic [CHR_BW+CHR_OFS_W-1:0] chr_addr,
   output logic                        chr_cs,
   output logic                        nt_page
);
   logic [BANK_W-1:0] sel_bank;
   logic              unused_bits;

   assign sel_bank = chr_bank[ppu_addr[12:10]];
   assign chr_addr = {sel_bank[CHR_BW-1:0], ppu_addr[CHR_OFS_W-1:0]};
   assign chr_cs   = ~ppu_addr[13];

   always_comb begin
      unique case (mirror)
         MIR_HORZ:  nt_page = ppu_addr[11];
         MIR_VERT:  nt_page = ppu_addr[10];
         MIR_ONE_A: nt_page = 1'b0;
         default:   nt_page = 1'b1;
      endcase
   end

   assign unused_bits = ^sel_bank;
endmodule

// File: rtl/nibble_bank_mapper.sv
`timescale 1ns/1ps
module nibble_bank_mapper
   import nbm_pkg::*;
#(
   parameter int PRG_BANKS = 32,
   parameter int CHR_BANKS = 256,
   parameter bit HAS_WRAM  = 1'b1,
   localparam int PRG_BW   = $clog2(PRG_BANKS),
   localparam int CHR_BW   = $clog2(CHR_BANKS),
   localparam int PRG_AW   = PRG_BW + PRG_OFS_W,
   localparam int CHR_AW   = CHR_BW + CHR_OFS_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_valid,
   input  logic                 cpu_we,
   input  logic [15:0]          cpu_addr,
   input  logic [7:0]           cpu_wdata,
   input  logic [13:0]          ppu_addr,
   output logic [PRG_AW-1:0]    prg_rom_addr,
   output logic                 prg_rom_cs,
   output logic [PRG_OFS_W-1:0] ram_addr,
   output logic                 ram_cs,
   output logic                 ram_oe,
   output logic                 ram_we,
   output logic [CHR_AW-1:0]    chr_addr,
   output logic                 chr_cs,
   output logic                 nt_page
);
   if (PRG_BANKS < 2 || PRG_BANKS > 256 || (PRG_BANKS & (PRG_BANKS - 1)) != 0) begin : g_bad_prg
      $error("PRG_BANKS must be a power of two from 2 to 256");
   end
   if (CHR_BANKS < 2 || CHR_BANKS > 256 || (CHR_BANKS & (CHR_BANKS - 1)) != 0) begin : g_bad_chr
      $error("CHR_BANKS must be a power of two from 2 to 256");
   end

   prg_banks_t prg_bank;
   chr_banks_t chr_bank;
   logic       ram_en, ram_wr;
   mirror_e    mirror;

   nbm_regfile u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cpu_valid & cpu_we),
      .addr     (cpu_addr),
      .wdata    (cpu_wdata),
      .prg_bank (prg_bank),
      .chr_bank (chr_bank),
      .ram_en   (ram_en),
      .ram_wr   (ram_wr),
      .mirror   (mirror)
   );

   nbm_prg_xlate #(.PRG_BW(PRG_BW), .HAS_WRAM(HAS_WRAM)) u_prg (
      .cpu_valid    (cpu_valid),
      .cpu_we       (cpu_we),
      .cpu_addr     (cpu_addr),
      .prg_bank     (prg_bank),
      .ram_en       (ram_en),
      .ram_wr       (ram_wr),
      .prg_rom_addr (prg_rom_addr),
      .prg_rom_cs   (prg_rom_cs),
      .ram_addr     (ram_addr),
      .ram_cs       (ram_cs),
      .ram_oe       (ram_oe),
      .ram_we       (ram_we)
   );

   nbm_chr_xlate #(.CHR_BW(CHR_BW)) u_chr (
      .ppu_addr (ppu_addr),
      .chr_bank (chr_bank),
      .mirror   (mirror),
      .chr_addr (chr_addr),
      .chr_cs   (chr_cs),
      .nt_page  (nt_page)
   );
endmodule

// File: rtl/nbm_chk.sv
`timescale 1ns/1ps
module nbm_chk
   import nbm_pkg::*;
#(
   parameter int PRG_BW = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cpu_valid,
   input logic                        cpu_we,
   input logic [15:0]                 cpu_addr,
   input logic [7:0]                  cpu_wdata,
   input logic [PRG_BW+PRG_OFS_W-1:0] prg_rom_addr,
   input logic                        prg_rom_cs,
   input logic                        ram_cs,
   input logic                        ram_oe,
   input logic                        ram_we,
   input prg_banks_t                  prg_bank,
   input chr_banks_t                  chr_bank
);
   logic wr;
   assign wr = cpu_valid & cpu_we;

   // R2
   lo_nibble_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (cpu_addr & 16'hF003) == 16'h8000) |=>
         (prg_bank[0][3:0] == $past(cpu_wdata[3:0]) && prg_bank[0][7:4] == $past(prg_bank[0][7:4])));

   // R2
   hi_nibble_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (cpu_addr & 16'hF003) == 16'hA001) |=>
         (chr_bank[0][7:4] == $past(cpu_wdata[3:0]) && chr_bank[0][3:0] == $past(chr_bank[0][3:0])));

   // R4
   fixed_top_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_we && cpu_addr[15:13] == 3'b111) |->
         (prg_rom_addr[PRG_BW+PRG_OFS_W-1:PRG_OFS_W] == {PRG_BW{1'b1}}));

   // R6
   ram_we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || ram_oe) |-> ram_cs);

   // R6
   ram_cs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs |-> (cpu_valid && cpu_addr[15:13] == 3'b011));

   // R7
   rom_cs_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prg_rom_cs |-> (cpu_valid && !cpu_we && cpu_addr[15]));

   // R9
   ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ((cpu_addr & 16'hF003) == 16'hF003 || (cpu_addr & 16'hF003) == 16'h9003 ||
              (cpu_addr & 16'hF000) == 16'hE000 || !cpu_addr[15])) |=>
         ($stable(prg_bank) && $stable(chr_bank)));
endmodule

bind nibble_bank_mapper nbm_chk #(.PRG_BW(PRG_BW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_valid    (cpu_valid),
   .cpu_we       (cpu_we),
   .cpu_addr     (cpu_addr),
   .cpu_wdata    (cpu_wdata),
   .prg_rom_addr (prg_rom_addr),
   .prg_rom_cs   (prg_rom_cs),
   .ram_cs       (ram_cs),
   .ram_oe       (ram_oe),
   .ram_we       (ram_we),
   .prg_bank     (prg_bank),
   .chr_bank     (chr_bank)
);

// File: tb/nibble_bank_mapper_tb.sv
`timescale 1ns/1ps
module nibble_bank_mapper_tb;
   localparam int PRG_BANKS = 32;
   localparam int CHR_BANKS = 256;
   localparam int PRG_AW = $clog2(PRG_BANKS) + 13;
   localparam int CHR_AW = $clog2(CHR_BANKS) + 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_valid = 1'b0, cpu_we = 1'b0;
   logic [15:0]       cpu_addr = '0;
   logic [7:0]        cpu_wdata = '0;
   logic [13:0]       ppu_addr = '0;
   logic [PRG_AW-1:0] prg_rom_addr;
   logic              prg_rom_cs;
   logic [12:0]       ram_addr;
   logic              ram_cs, ram_oe, ram_we;
   logic [CHR_AW-1:0] chr_addr;
   logic              chr_cs, nt_page;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [7:0] m_prg [3];
   logic [7:0] m_chr [8];
   logic       m_en, m_wr;
   logic [1:0] m_mir;

   always #2.5 clk = ~clk;

   nibble_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr),
      .prg_rom_addr(prg_rom_addr), .prg_rom_cs(prg_rom_cs), .ram_addr(ram_addr),
      .ram_cs(ram_cs), .ram_oe(ram_oe), .ram_we(ram_we),
      .chr_addr(chr_addr), .chr_cs(chr_cs), .nt_page(nt_page)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void set_nib(ref logic [7:0] r, input logic hi, input logic [3:0] d);
      if (hi) r[7:4] = d; else r[3:0] = d;
   endfunction

   // Model of R2/R3/R5/R6/R8/R9 decoding
   function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
      logic [15:0] k;
      k = a & 16'hF003;
      if (!a[15]) return;
      case (k)
         16'h8000, 16'h8001: set_nib(m_prg[0], a[0], d[3:0]);
         16'h8002, 16'h8003: set_nib(m_prg[1], a[0], d[3:0]);
         16'h9000, 16'h9001: set_nib(m_prg[2], a[0], d[3:0]);
         16'h9002: begin m_en = d[0]; m_wr = d[1]; end
         16'hF002: m_mir = d[1:0];
         default: begin
            if (k[15:12] >= 4'hA && k[15:12] <= 4'hD)
               set_nib(m_chr[(k[15:12] - 4'hA) * 2 + k[1]], a[0], d[3:0]);
         end
      endcase
   endfunction

   function automatic longint exp_prg(input logic [15:0] a);
      int b;
      b = (a[14:13] == 2'd3) ? PRG_BANKS - 1 : int'(m_prg[a[14:13]]) % PRG_BANKS;
      return (longint'(b) << 13) | a[12:0];
   endfunction

   function automatic longint exp_chr(input logic [13:0] a);
      return (longint'(int'(m_chr[a[12:10]]) % CHR_BANKS) << 10) | a[9:0];
   endfunction

   function automatic logic exp_nt(input logic [13:0] a);
      case (m_mir)
         2'd0: return a[11];
         2'd1: return a[10];
         2'd2: return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_valid = 1'b0; cpu_we = 1'b0;
      model_write(a, d);
   endtask

   task automatic check_cpu_read(input logic [15:0] a, input string req);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      #1;
      chk(prg_rom_cs == a[15], "R7", {req, " rom_cs"}, prg_rom_cs, a[15]);
      if (a[15])
         chk(prg_rom_addr == exp_prg(a), req, "prg_rom_addr", prg_rom_addr, exp_prg(a));
      if (a[15:13] == 3'b011) begin
         chk(ram_cs == m_en && ram_oe == m_en && !ram_we, "R6", "ram read strobes",
             {ram_cs, ram_oe, ram_we}, {m_en, m_en, 1'b0});
         chk(ram_addr == a[12:0], "R6", "ram_addr", ram_addr, a[12:0]);
      end else begin
         chk(!ram_cs, "R6", "ram_cs outside range", ram_cs, 0);
      end
      cpu_valid = 1'b0;
   endtask

   task automatic check_ram_write(input logic [15:0] a);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = 8'h5A;
      #1;
      chk(ram_cs == m_en && !ram_oe && ram_we == (m_en & m_wr) && !prg_rom_cs, "R6",
          "ram write strobes", {prg_rom_cs, ram_cs, ram_oe, ram_we},
          {1'b0, m_en, 1'b0, m_en & m_wr});
      cpu_valid = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic check_ppu(input logic [13:0] a, input string req);
      @(negedge clk);
      ppu_addr = a;
      #1;
      chk(chr_cs == !a[13], "R5", "chr_cs", chr_cs, !a[13]);
      if (!a[13])
         chk(chr_addr == exp_chr(a), req, "chr_addr", chr_addr, exp_chr(a));
      chk(nt_page == exp_nt(a), "R8", "nt_page", nt_page, exp_nt(a));
   endtask

   task automatic sweep(input string req);
      for (int w = 0; w < 4; w++)
         check_cpu_read(16'h8000 | (16'(w) << 13) | 16'h0123, req);
      for (int k = 0; k < 8; k++)
         check_ppu(14'(k << 10) | 14'h2A5, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1971));
      for (int i = 0; i < 3; i++) m_prg[i] = '0;
      for (int i = 0; i < 8; i++) m_chr[i] = '0;
      m_en = 1'b0; m_wr = 1'b0; m_mir = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      sweep("R1");
      check_cpu_read(16'h6010, "R1");
      check_ppu(14'h2800, "R1");
      check_ppu(14'h2400, "R1");

      // R2 nibble preservation, R3 switchable windows
      wr(16'h8000, 8'hF3); wr(16'h8001, 8'hA2);
      wr(16'h8002, 8'h04); wr(16'h8003, 8'h01);
      wr(16'h9000, 8'h07); wr(16'h9001, 8'h03);
      sweep("R3");
      wr(16'h8001, 8'h05);
      check_cpu_read(16'h8ABC, "R2");
      wr(16'h8000, 8'h0E);
      check_cpu_read(16'h9FFF, "R2");

      // R4 fixed top window after writes everywhere
      check_cpu_read(16'hE000, "R4");
      check_cpu_read(16'hFFFF, "R4");

      // R5 all eight graphics windows, both nibbles
      for (int k = 0; k < 8; k++) begin
         logic [15:0] base;
         base = 16'hA000 + 16'(k / 2) * 16'h1000 + 16'(k % 2) * 16'd2;
         wr(base, 8'(k + 1));
         wr(base | 16'd1, 8'(8 - k));
      end
      sweep("R5");
      wr(16'hA001, 8'hC9);
      check_ppu(14'h0155, "R2");

      // R6 RAM modes: off, read-only, read-write, and bit1 without bit0
      wr(16'h9002, 8'h00);
      check_cpu_read(16'h7123, "R6"); check_ram_write(16'h6456);
      wr(16'h9002, 8'h01);
      check_cpu_read(16'h7123, "R6"); check_ram_write(16'h6456);
      wr(16'h9002, 8'h03);
      check_cpu_read(16'h7FFF, "R6"); check_ram_write(16'h6000);
      wr(16'h9002, 8'h02);
      check_cpu_read(16'h6001, "R6"); check_ram_write(16'h7001);
      wr(16'h9002, 8'h03);

      // R8 all mirroring modes
      for (int m = 0; m < 4; m++) begin
         wr(16'hF002, 8'(m) | 8'hFC);
         for (int p = 0; p < 4; p++) check_ppu(14'h2000 | 14'(p << 10) | 14'h01F, "R8");
      end

      // R9 ignored decodes and writes below $8000, then full sweep
      wr(16'hF003, 8'hFF); wr(16'h9003, 8'hFF); wr(16'hF000, 8'hFF);
      wr(16'hF001, 8'h0F); wr(16'hE000, 8'hFF); wr(16'hE003, 8'hFF);
      wr(16'h6000, 8'hFF); wr(16'h7F03, 8'hFF); wr(16'h1001, 8'hFF);
      sweep("R9");
      check_ppu(14'h2C00, "R9");
      check_ram_write(16'h6100);

      // R10 aliased decode with bits [11:2] set
      wr(16'h8FFC, 8'h09);
      check_cpu_read(16'h8004, "R10");
      wr(16'hDFFF, 8'h06);
      check_ppu(14'h1FFF, "R10");

      // Random aliased writes mixed with translation checks
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         a = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
         wr(a, 8'($urandom));
         check_cpu_read(16'($urandom), "R3");
         check_ppu(14'($urandom), "R5");
      end
      sweep("R9");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule